// File: doc/BRIEF.md
# Clock-Recovery Lock Supervisor with Reference Fallback

This block watches a clock-recovery loop and chooses what the loop should follow: the incoming serial data or a local reference clock. It measures the recovered rate by adding up recovered-clock events over a fixed number of reference ticks. It compares that total with the ideal count and steers the loop source. It also drives an active-low lock indicator. When the input has no usable signal, or when software forces the reference, the loop stays on the reference so that downstream clocking never stops.

While the acquisition conditions hold but the measured rate is outside the limit, the supervisor keeps retrying. Each try runs one window on data, then falls back for one window on the reference, and the indicator follows every switch. The source select is registered and moves only at the end of a measurement window. That point is the glitch-free switching instant for the clock multiplexer downstream.

Top module: `cdr_lock_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `src_data` is 0 (reference) and `lockdet_n` is 1 (inactive). The window tick count and the event total are cleared.
- R2: A measurement window spans `WIN_TICKS` cycles in which `ref_tick` is high. `src_data` changes only in the cycle that follows the cycle in which the last tick of a window is taken.
- R3: While `force_ref_n` is 0, `lockdet_n` is 1 from the next cycle on. At the next window end `src_data` becomes 0, and it stays 0 while the force is held.
- R4: While `sig_det` is 0, `lockdet_n` is 1 from the next cycle on. At the next window end `src_data` becomes 0, and it stays 0 while the flag is low.
- R5: If `run_ok` is 0 at a window end, `src_data` becomes 0 and `lockdet_n` becomes 1.
- R6: If the loop is on data (`src_data`=1), the acquisition conditions hold, and the `rec_inc` total over a window differs from `WIN_TICKS` by more than `TOL_CNT`, then at that window end `src_data` becomes 0 and `lockdet_n` becomes 1. With the default values this means more than 1 event in 4096, about 244 ppm.
- R7: If the loop is on the reference at a window end, and `force_ref_n`, `sig_det` and `run_ok` are all 1 at that point, then `src_data` becomes 1 and `lockdet_n` becomes 0. This retry comes one full window after the fallback, so a persistent rate error makes both outputs alternate every window.
- R8: On data with the conditions holding, a window total within `TOL_CNT` of `WIN_TICKS` keeps `src_data` at 1 and `lockdet_n` at 0. A difference of exactly `TOL_CNT` counts as within the limit.
- R9: `lockdet_n` is 0 only while `src_data` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One reference tick per cycle in which it is high |
| rec_inc | input | INC_W | Recovered-clock events counted in this cycle |
| sig_det | input | 1 | Valid signal present on the serial input |
| run_ok | input | 1 | Run-length check on the serial input passes |
| force_ref_n | input | 1 | Active low: keep the loop on the reference |
| src_data | output | 1 | Loop source select: 1 data, 0 reference |
| lockdet_n | output | 1 | Active-low lock indicator |

## Verification
The checker watches every cycle for these properties:
- the source moves only after a window end;
- an asserted force or a lost signal drives the indicator inactive within one cycle;
- an active indicator implies the data source;
- the decision at each window end agrees with the rate-error, retry and fallback rules.

Only the directed scenarios can show the following:
- the exact tolerance edge, with totals at ±1 accepted and ±2 rejected;
- the window-by-window alternation pattern;
- recovery once force, signal or run-length conditions return.

// File: rtl/cdr_lock_pkg.sv
package cdr_lock_pkg;

   typedef enum logic {
      SRC_REF  = 1'b0,
      SRC_DATA = 1'b1
   } loop_src_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/cdr_win_timer.sv
module cdr_win_timer #(
   parameter int unsigned WIN_TICKS = 4096
) (
   input  logic clk,
   input  logic rst,
   input  logic ref_tick,
   output logic win_end
);
   import cdr_lock_pkg::*;

   localparam int unsigned CNT_W = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
   localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(WIN_TICKS - 1);

   logic [CNT_W-1:0] tick_cnt_q;

   generate
      if (is_pow2(WIN_TICKS)) begin : g_wrap
         // Power-of-two window: the counter wraps by itself.
         assign win_end = ref_tick & (&tick_cnt_q);

         always_ff @(posedge clk) begin
            if (rst) begin
               tick_cnt_q <= '0;
            end else if (ref_tick) begin
               tick_cnt_q <= tick_cnt_q + CNT_W'(1);
            end
         end
      end else begin : g_cmp
         // Arbitrary window: explicit terminal compare and reload.
         assign win_end = ref_tick & (tick_cnt_q == LAST_TICK);

         always_ff @(posedge clk) begin
            if (rst) begin
               tick_cnt_q <= '0;
            end else if (ref_tick) begin
               if (tick_cnt_q == LAST_TICK) begin
                  tick_cnt_q <= '0;
               end else begin
                  tick_cnt_q <= tick_cnt_q + CNT_W'(1);
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/cdr_freq_meter.sv
module cdr_freq_meter #(
   parameter int unsigned WIN_TICKS = 4096,
   parameter int unsigned TOL_CNT   = 1,
   parameter int unsigned INC_W     = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             win_end,
   input  logic [INC_W-1:0] rec_inc,
   output logic             freq_bad
);

   localparam int unsigned INC_MAX = (1 << INC_W) - 1;
   localparam int unsigned ACC_W   = $clog2(WIN_TICKS * INC_MAX + 1) + 1;
   localparam logic [ACC_W-1:0] IDEAL = ACC_W'(WIN_TICKS);
   localparam logic [ACC_W-1:0] TOL   = ACC_W'(TOL_CNT);

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] total;
   logic [ACC_W-1:0] dev;

   // The total includes the events of the window's last cycle.
   assign total = acc_q + ACC_W'(rec_inc);
   assign dev   = (total >= IDEAL) ? (total - IDEAL) : (IDEAL - total);

   generate
      if (TOL_CNT == 0) begin : g_exact
         assign freq_bad = (total != IDEAL);
      end else begin : g_band
         assign freq_bad = (dev > TOL);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
      end else if (win_end) begin
         acc_q <= '0;
      end else begin
         acc_q <= total;
      end
   end

endmodule

// File: rtl/cdr_src_fsm.sv
module cdr_src_fsm (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     win_end,
   input  logic                     acq_ok,
   input  logic                     hold_off,
   input  logic                     freq_bad,
   output cdr_lock_pkg::loop_src_e  src_q,
   output logic                     lock_n_q
);
   import cdr_lock_pkg::*;

   loop_src_e src_nxt;
   logic      lock_n_nxt;

   always_comb begin
      src_nxt    = src_q;
      lock_n_nxt = lock_n_q;
      if (win_end) begin
         unique case (src_q)
            SRC_REF: begin
               // One window has passed on the reference: retry data.
               if (acq_ok) begin
                  src_nxt    = SRC_DATA;
                  lock_n_nxt = 1'b0;
               end else begin
                  lock_n_nxt = 1'b1;
               end
            end
            SRC_DATA: begin
               if (!acq_ok || freq_bad) begin
                  src_nxt    = SRC_REF;
                  lock_n_nxt = 1'b1;
               end else begin
                  lock_n_nxt = 1'b0;
               end
            end
            default: begin
               src_nxt    = SRC_REF;
               lock_n_nxt = 1'b1;
            end
         endcase
      end
      // Force or signal loss drops the indicator at once.
      if (hold_off) begin
         lock_n_nxt = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         src_q    <= SRC_REF;
         lock_n_q <= 1'b1;
      end else begin
         src_q    <= src_nxt;
         lock_n_q <= lock_n_nxt;
      end
   end

endmodule

// File: rtl/cdr_lock_ctrl.sv
module cdr_lock_ctrl #(
   parameter int unsigned WIN_TICKS = 4096,
   parameter int unsigned TOL_CNT   = 1,
   parameter int unsigned INC_W     = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ref_tick,
   input  logic [INC_W-1:0] rec_inc,
   input  logic             sig_det,
   input  logic             run_ok,
   input  logic             force_ref_n,
   output logic             src_data,
   output logic             lockdet_n
);
   import cdr_lock_pkg::*;

   generate
      if (WIN_TICKS < 2) begin : g_bad_win
         initial $fatal(1, "cdr_lock_ctrl: WIN_TICKS must be at least 2");
      end
      if (TOL_CNT >= WIN_TICKS) begin : g_bad_tol
         initial $fatal(1, "cdr_lock_ctrl: TOL_CNT must be below WIN_TICKS");
      end
      if (INC_W < 1 || INC_W > 8) begin : g_bad_inc
         initial $fatal(1, "cdr_lock_ctrl: INC_W out of range 1..8");
      end
   endgenerate

   logic      win_end;
   logic      freq_bad;
   logic      acq_ok;
   logic      hold_off;
   loop_src_e src_q;
   logic      lock_n_q;

   assign acq_ok   = force_ref_n & sig_det & run_ok;
   assign hold_off = ~force_ref_n | ~sig_det;

   cdr_win_timer #(
      .WIN_TICKS (WIN_TICKS)
   ) timer_i (
      .clk      (clk),
      .rst      (rst),
      .ref_tick (ref_tick),
      .win_end  (win_end)
   );

   cdr_freq_meter #(
      .WIN_TICKS (WIN_TICKS),
      .TOL_CNT   (TOL_CNT),
      .INC_W     (INC_W)
   ) meter_i (
      .clk      (clk),
      .rst      (rst),
      .win_end  (win_end),
      .rec_inc  (rec_inc),
      .freq_bad (freq_bad)
   );

   cdr_src_fsm fsm_i (
      .clk      (clk),
      .rst      (rst),
      .win_end  (win_end),
      .acq_ok   (acq_ok),
      .hold_off (hold_off),
      .freq_bad (freq_bad),
      .src_q    (src_q),
      .lock_n_q (lock_n_q)
   );

   assign src_data  = (src_q == SRC_DATA);
   assign lockdet_n = lock_n_q;

endmodule

// File: rtl/cdr_lock_ctrl_chk.sv
module cdr_lock_ctrl_chk (
   input logic clk,
   input logic rst,
   input logic force_ref_n,
   input logic sig_det,
   input logic run_ok,
   input logic src_data,
   input logic lockdet_n,
   input logic win_end,
   input logic freq_bad
);

   assert_src_at_boundary_R2: assert property (@(posedge clk) disable iff (rst)
      !$stable(src_data) |-> $past(win_end));

   assert_force_drops_lock_R3: assert property (@(posedge clk) disable iff (rst)
      !force_ref_n |=> lockdet_n);

   assert_force_falls_back_R3: assert property (@(posedge clk) disable iff (rst)
      (win_end && !force_ref_n) |=> !src_data);

   assert_sigloss_drops_lock_R4: assert property (@(posedge clk) disable iff (rst)
      !sig_det |=> lockdet_n);

   assert_runlen_falls_back_R5: assert property (@(posedge clk) disable iff (rst)
      (win_end && !run_ok) |=> (!src_data && lockdet_n));

   assert_freq_err_falls_back_R6: assert property (@(posedge clk) disable iff (rst)
      (win_end && src_data && freq_bad) |=> (!src_data && lockdet_n));

   assert_retry_data_R7: assert property (@(posedge clk) disable iff (rst)
      (win_end && !src_data && force_ref_n && sig_det && run_ok) |=> (src_data && !lockdet_n));

   assert_hold_data_R8: assert property (@(posedge clk) disable iff (rst)
      (win_end && src_data && !freq_bad && force_ref_n && sig_det && run_ok) |=> (src_data && !lockdet_n));

   assert_lock_implies_data_R9: assert property (@(posedge clk) disable iff (rst)
      !lockdet_n |-> src_data);

endmodule

bind cdr_lock_ctrl cdr_lock_ctrl_chk chk_i (
   .clk         (clk),
   .rst         (rst),
   .force_ref_n (force_ref_n),
   .sig_det     (sig_det),
   .run_ok      (run_ok),
   .src_data    (src_data),
   .lockdet_n   (lockdet_n),
   .win_end     (win_end),
   .freq_bad    (freq_bad)
);

// File: tb/cdr_lock_ctrl_tb_top.sv
module cdr_lock_ctrl_tb_top;

   localparam int unsigned WIN   = 64;
   localparam int unsigned TOL   = 1;
   localparam int unsigned INC_W = 3;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             ref_tick = 1'b1;
   logic [INC_W-1:0] rec_inc;
   logic             sig_det = 1'b1;
   logic             run_ok = 1'b1;
   logic             force_ref_n = 1'b1;
   logic             src_data;
   logic             lockdet_n;

   int errors = 0;
   int checks = 0;
   int err_set = 0;     // Window total offset applied by the stimulus
   int ph = 0;          // Bench view of the tick position inside a window
   bit finished = 1'b0;

   always #5 clk = ~clk;

   cdr_lock_ctrl #(
      .WIN_TICKS (WIN),
      .TOL_CNT   (TOL),
      .INC_W     (INC_W)
   ) dut_i (
      .clk         (clk),
      .rst         (rst),
      .ref_tick    (ref_tick),
      .rec_inc     (rec_inc),
      .sig_det     (sig_det),
      .run_ok      (run_ok),
      .force_ref_n (force_ref_n),
      .src_data    (src_data),
      .lockdet_n   (lockdet_n)
   );

   // Stimulus position: a window is WIN ticks long and starts after reset.
   always @(posedge clk) begin
      if (rst) ph <= 0;
      else if (ref_tick) ph <= (ph == int'(WIN) - 1) ? 0 : ph + 1;
   end

   // One event per tick, with the offset folded into the window's first cycles.
   always_comb begin
      if (err_set >= 0) rec_inc = (ph == 0) ? INC_W'(1 + err_set) : INC_W'(1);
      else              rec_inc = (ph < -err_set) ? INC_W'(0) : INC_W'(1);
   end

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
      end
   endtask

   // Returns at the falling edge right after a window end.
   task automatic wait_bound();
      @(negedge clk);
      while (ph != 0) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1", "src during reset", src_data, 1'b0);
      chk("R1", "lockdet during reset", lockdet_n, 1'b1);
      rst = 1'b0;
      @(negedge clk);
      chk("R1", "src after reset", src_data, 1'b0);
      chk("R1", "lockdet after reset", lockdet_n, 1'b1);
   endtask

   task automatic t_acquire();
      repeat (int'(WIN) - 4) @(negedge clk);
      chk("R2", "src before first window end", src_data, 1'b0);
      wait_bound();
      chk("R7", "src after first window", src_data, 1'b1);
      chk("R7", "lockdet after first window", lockdet_n, 1'b0);
   endtask

   task automatic t_tolerance();
      err_set = 1;
      wait_bound();
      chk("R8", "src at +1 offset", src_data, 1'b1);
      chk("R8", "lockdet at +1 offset", lockdet_n, 1'b0);
      err_set = -1;
      wait_bound();
      chk("R8", "src at -1 offset", src_data, 1'b1);
      chk("R8", "lockdet at -1 offset", lockdet_n, 1'b0);
      err_set = 0;
   endtask

   task automatic t_toggle(input int off);
      err_set = off;
      for (int k = 0; k < 2; k++) begin
         wait_bound();
         chk("R6", "src falls back on rate error", src_data, 1'b0);
         chk("R6", "lockdet inactive on rate error", lockdet_n, 1'b1);
         wait_bound();
         chk("R7", "src retries data", src_data, 1'b1);
         chk("R7", "lockdet active on retry", lockdet_n, 1'b0);
      end
      err_set = 0;
      wait_bound();
      chk("R8", "src holds after rate restored", src_data, 1'b1);
   endtask

   task automatic t_force();
      repeat (6) @(negedge clk);
      force_ref_n = 1'b0;
      @(negedge clk);
      chk("R3", "lockdet one cycle after force", lockdet_n, 1'b1);
      chk("R2", "src held mid-window under force", src_data, 1'b1);
      wait_bound();
      chk("R3", "src on reference under force", src_data, 1'b0);
      wait_bound();
      chk("R3", "src stays on reference", src_data, 1'b0);
      chk("R3", "lockdet stays inactive", lockdet_n, 1'b1);
      force_ref_n = 1'b1;
      wait_bound();
      chk("R7", "src returns after force release", src_data, 1'b1);
      chk("R9", "lockdet active with data", lockdet_n, 1'b0);
   endtask

   task automatic t_sigloss();
      repeat (10) @(negedge clk);
      sig_det = 1'b0;
      @(negedge clk);
      chk("R4", "lockdet one cycle after signal loss", lockdet_n, 1'b1);
      chk("R2", "src held mid-window on signal loss", src_data, 1'b1);
      wait_bound();
      chk("R4", "src on reference without signal", src_data, 1'b0);
      wait_bound();
      chk("R4", "src stays on reference", src_data, 1'b0);
      sig_det = 1'b1;
      wait_bound();
      chk("R7", "src returns with signal", src_data, 1'b1);
   endtask

   task automatic t_runlen();
      repeat (10) @(negedge clk);
      run_ok = 1'b0;
      @(negedge clk);
      chk("R2", "src held mid-window on run-length fail", src_data, 1'b1);
      wait_bound();
      chk("R5", "src on reference on run-length fail", src_data, 1'b0);
      chk("R5", "lockdet inactive on run-length fail", lockdet_n, 1'b1);
      wait_bound();
      chk("R5", "src stays on reference", src_data, 1'b0);
      chk("R9", "lockdet inactive on reference", lockdet_n, 1'b1);
      run_ok = 1'b1;
      wait_bound();
      chk("R7", "src returns with run-length ok", src_data, 1'b1);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_acquire();
      t_tolerance();
      t_toggle(2);
      t_toggle(-2);
      t_force();
      t_sigloss();
      t_runlen();
      summary();
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

endmodule